// File: doc/BRIEF.md
# EPP Cycle Gating Engine

This block sits between a host register bus and an enhanced parallel port peripheral. It holds the data-out and control registers of a parallel port, reports a status byte, and exposes two windows (an address window and a data window) through which the host starts peripheral address or data cycles. Before any peripheral cycle begins, the engine compares a group of control bits against one fixed pattern for writes and another for reads. A request that does not match is completed at once: a write is dropped, and a read returns all ones at the access width.

A peripheral cycle is carried out over a request/acknowledge byte interface. Data-window accesses may be 8, 16 or 32 bits wide and are moved one byte at a time, least-significant byte first. A peripheral error, or an acknowledge that does not arrive within a bounded number of clocks, ends the transfer early and sets a sticky timeout flag. Software sees this flag in status bit 0 and clears it by writing a 1 to that bit. While a transfer is in progress the host sees a busy signal, and every accepted request ends with a one-cycle done pulse.

Top module: `eppCycleEngine`

## Requirements
- R1: Register offsets on `hostAddr` are 0 data-out, 1 status, 2 control, 3 address window, 4 data window. Reads of offsets 5 to 7 return 0x000000FF, and writes to them change nothing.
- R2: After reset, control reads 0xCC, data-out reads 0xFF, the timeout flag is 0, `hostBusy` is low and `perReq` is low.
- R3: A control write stores the written byte with bits 7:6 forced to 1. A control or data-out write whose stored value equals the value already held raises no load pulse. A write that changes the value raises `portCtrlLoad` or `portDataLoad` for one cycle and updates `portCtrl` or `portData`.
- R4: A window write starts a peripheral cycle only if control bits {5,3,2,1,0} equal 0b0_0100 (only bit 2 set). Otherwise it is dropped with no `perReq`, and `hostDone` pulses the cycle after the request.
- R5: A window read starts a peripheral cycle only if control bits {5,3,2,1,0} equal 0b1_0100 (bits 5 and 2 set). Otherwise it returns all ones at the access width: 8 bits for the address window, and 8, 16 or 32 bits for the data window as selected by `hostSize`.
- R6: `hostSize` 0, 1 and 2 (3 acts as 2) select 1, 2 and 4 bytes at the data window. The address window always moves one byte. Byte i travels over bits 8i+7:8i, lowest byte first, and `perAddrCyc` is 1 only for the address window.
- R7: `perReq` stays high with `perWbyte`, `perWrite` and `perAddrCyc` stable until `perAck` or `perErr`. After an acknowledge, `perReq` is low for exactly one cycle before the next byte.
- R8: `perErr`, or `ACK_TIMEOUT` consecutive `perReq` cycles without `perAck`, ends the transfer and sets the timeout flag. Read bytes not yet received stay 0xFF in the result.
- R9: A status read returns bits 7:1 from `perStatus` and the timeout flag in bit 0.
- R10: A status write with bit 0 set clears the timeout flag. With bit 0 clear, the flag is left unchanged.
- R11: `hostBusy` is high from the cycle after an accepted window cycle until the cycle in which `hostDone` pulses. It is never low while `perReq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostReq | input | 1 | One-cycle access request, honoured while hostBusy is low |
| hostWr | input | 1 | 1 write, 0 read |
| hostAddr | input | 3 | Register offset |
| hostSize | input | 2 | Access width: 0 byte, 1 half, 2/3 word |
| hostWdata | input | 32 | Write data |
| hostRdata | output | 32 | Read result, valid with hostDone |
| hostDone | output | 1 | One-cycle completion pulse |
| hostBusy | output | 1 | Window transfer in progress |
| portData | output | 8 | Data-out register |
| portDataLoad | output | 1 | Pulse when data-out changes |
| portCtrl | output | 8 | Control register |
| portCtrlLoad | output | 1 | Pulse when control changes |
| perStatus | input | 7 | Peripheral status lines for bits 7:1 |
| perReq | output | 1 | Peripheral byte request |
| perAddrCyc | output | 1 | 1 address cycle, 0 data cycle |
| perWrite | output | 1 | 1 write byte, 0 read byte |
| perWbyte | output | 8 | Byte sent to the peripheral |
| perRbyte | input | 8 | Byte returned by the peripheral |
| perAck | input | 1 | Byte accepted or returned |
| perErr | input | 1 | Byte failed |

## Verification
A wrong gate decode shows up directly on `perReq`. A dropped cycle that should have run, or a peripheral request made under a forbidden control pattern, is visible on the first clock after the host request. A wrong byte index or a lost lane shows as a misordered peripheral byte or a wrong assembled read word when `hostDone` pulses. A broken timeout counter or sticky flag shows as a wrong count of request cycles, or as a wrong status bit 0 on the next status read. Stale compare values for data-out and control show up as load pulses that appear or disappear on the cycle after the write.

// File: rtl/eppPkg.sv
package eppPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_GAP  = 2'd2
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic regAcc;   // plain register access or gated-off window access
    logic start;    // window transfer begins
    logic byteAck;  // current byte acknowledged
    logic finish;   // transfer ends this cycle
    logic setTo;    // failure: raise sticky timeout flag
  } strobe_t;

  localparam logic [2:0] OFF_DATA  = 3'd0;
  localparam logic [2:0] OFF_STAT  = 3'd1;
  localparam logic [2:0] OFF_CTRL  = 3'd2;
  localparam logic [2:0] OFF_EADDR = 3'd3;
  localparam logic [2:0] OFF_EDATA = 3'd4;

  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WR    = 8'h04;
  localparam logic [7:0] GATE_RD    = 8'h24;
  localparam logic [7:0] CTRL_FORCE = 8'hC0;
  localparam logic [7:0] CTRL_RST   = 8'hCC;
  localparam logic [7:0] DATA_RST   = 8'hFF;

  function automatic int sizeToBytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/eppCtrl.sv
module eppCtrl
  import eppPkg::*;
#(
  parameter int BYTES       = 4,
  parameter int IDX_W       = 2,
  parameter int ACK_TIMEOUT = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostReq,
  input  logic             hostWr,
  input  logic [2:0]       hostAddr,
  input  logic [1:0]       hostSize,
  input  logic             gateWr,
  input  logic             gateRd,
  input  logic             perAck,
  input  logic             perErr,
  output strobe_t          stb,
  output logic [IDX_W-1:0] byteIdx,
  output logic [IDX_W-1:0] lastIdx,
  output logic             perReq,
  output logic             hostBusy
);
  localparam int CNT_W = (ACK_TIMEOUT > 2) ? $clog2(ACK_TIMEOUT) : 1;
  localparam logic [CNT_W-1:0] WAIT_LIMIT = CNT_W'(ACK_TIMEOUT - 1);

  state_e           state;
  logic [CNT_W-1:0] waitCnt;
  logic             isWindow;
  logic             gateOk;
  logic [IDX_W-1:0] startLast;

  assign isWindow = (hostAddr == OFF_EADDR) || (hostAddr == OFF_EDATA);
  assign gateOk   = hostWr ? gateWr : gateRd;
  assign perReq   = (state == ST_REQ);
  assign hostBusy = (state != ST_IDLE);

  always_comb begin
    int nb;
    nb = (hostAddr == OFF_EADDR) ? 1 : sizeToBytes(hostSize);
    if (nb > BYTES) nb = BYTES;
    startLast = IDX_W'(nb - 1);
  end

  always_comb begin
    stb = '0;
    if (state == ST_IDLE && hostReq) begin
      if (isWindow && gateOk) stb.start  = 1'b1;
      else                    stb.regAcc = 1'b1;
    end else if (state == ST_REQ) begin
      if (perErr || (!perAck && waitCnt == WAIT_LIMIT)) begin
        stb.setTo  = 1'b1;
        stb.finish = 1'b1;
      end else if (perAck) begin
        stb.byteAck = 1'b1;
        stb.finish  = (byteIdx == lastIdx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      byteIdx <= '0;
      lastIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (stb.start) begin
          state   <= ST_REQ;
          waitCnt <= '0;
          byteIdx <= '0;
          lastIdx <= startLast;
        end
        ST_REQ: begin
          if (stb.finish)       state <= ST_IDLE;
          else if (stb.byteAck) begin
            state   <= ST_GAP;
            byteIdx <= byteIdx + 1'b1;
          end else              waitCnt <= waitCnt + 1'b1;
        end
        ST_GAP: begin
          state   <= ST_REQ;
          waitCnt <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eppDatapath.sv
module eppDatapath
  import eppPkg::*;
#(
  parameter int BYTES = 4,
  parameter int IDX_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic               hostWr,
  input  logic [2:0]         hostAddr,
  input  logic [1:0]         hostSize,
  input  logic [BYTES*8-1:0] hostWdata,
  input  logic [IDX_W-1:0]   byteIdx,
  input  logic [IDX_W-1:0]   lastIdx,
  input  logic [7:1]         perStatus,
  input  logic [7:0]         perRbyte,
  output logic [BYTES*8-1:0] hostRdata,
  output logic               hostDone,
  output logic [7:0]         portData,
  output logic               portDataLoad,
  output logic [7:0]         portCtrl,
  output logic               portCtrlLoad,
  output logic [7:0]         perWbyte,
  output logic               perWrite,
  output logic               perAddrCyc,
  output logic               gateWr,
  output logic               gateRd
);
  localparam int DATA_W = BYTES * 8;

  logic [7:0]            dataReg, ctrlReg, ctrlNew;
  logic                  toFlag, xWrite, xAddr;
  logic [BYTES-1:0][7:0] xferBuf, bufNext, finishData, laneOnes;
  logic [DATA_W-1:0]     regRead;

  assign ctrlNew  = hostWdata[7:0] | CTRL_FORCE;
  assign gateWr   = (ctrlReg & GATE_MASK) == GATE_WR;
  assign gateRd   = (ctrlReg & GATE_MASK) == GATE_RD;
  assign portData = dataReg;
  assign portCtrl = ctrlReg;
  assign perWbyte = xferBuf[byteIdx];
  assign perWrite = xWrite;
  assign perAddrCyc = xAddr;

  always_comb begin
    bufNext = xferBuf;
    if (stb.byteAck && !xWrite) bufNext[byteIdx] = perRbyte;
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign laneOnes[b]   = (b < sizeToBytes(hostSize)) ? 8'hFF : 8'h00;
    assign finishData[b] = (b <= int'(lastIdx)) ? bufNext[b] : 8'h00;
  end

  always_comb begin
    case (hostAddr)
      OFF_DATA:  regRead = DATA_W'(dataReg);
      OFF_STAT:  regRead = DATA_W'({perStatus, toFlag});
      OFF_CTRL:  regRead = DATA_W'(ctrlReg);
      OFF_EDATA: regRead = laneOnes;
      default:   regRead = DATA_W'(8'hFF);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg      <= DATA_RST;
      ctrlReg      <= CTRL_RST;
      toFlag       <= 1'b0;
      xWrite       <= 1'b0;
      xAddr        <= 1'b0;
      xferBuf      <= '1;
      hostRdata    <= '0;
      hostDone     <= 1'b0;
      portDataLoad <= 1'b0;
      portCtrlLoad <= 1'b0;
    end else begin
      hostDone     <= stb.regAcc | stb.finish;
      portDataLoad <= 1'b0;
      portCtrlLoad <= 1'b0;
      if (stb.regAcc) begin
        if (hostWr) begin
          hostRdata <= '0;
          case (hostAddr)
            OFF_DATA: if (hostWdata[7:0] != dataReg) begin
              dataReg      <= hostWdata[7:0];
              portDataLoad <= 1'b1;
            end
            OFF_STAT: if (hostWdata[0]) toFlag <= 1'b0;
            OFF_CTRL: if (ctrlNew != ctrlReg) begin
              ctrlReg      <= ctrlNew;
              portCtrlLoad <= 1'b1;
            end
            default: ;
          endcase
        end else begin
          hostRdata <= regRead;
        end
      end
      if (stb.start) begin
        xWrite  <= hostWr;
        xAddr   <= (hostAddr == OFF_EADDR);
        xferBuf <= hostWr ? hostWdata : '1;
      end
      if (stb.byteAck) xferBuf <= bufNext;
      if (stb.setTo)   toFlag  <= 1'b1;
      if (stb.finish)  hostRdata <= xWrite ? '0 : finishData;
    end
  end

endmodule

// File: rtl/eppCycleEngine.sv
module eppCycleEngine
  import eppPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ACK_TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostReq,
  input  logic              hostWr,
  input  logic [2:0]        hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostDone,
  output logic              hostBusy,
  output logic [7:0]        portData,
  output logic              portDataLoad,
  output logic [7:0]        portCtrl,
  output logic              portCtrlLoad,
  input  logic [7:1]        perStatus,
  output logic              perReq,
  output logic              perAddrCyc,
  output logic              perWrite,
  output logic [7:0]        perWbyte,
  input  logic [7:0]        perRbyte,
  input  logic              perAck,
  input  logic              perErr
);
  localparam int BYTES = DATA_W / 8;
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  strobe_t          stb;
  logic [IDX_W-1:0] byteIdx, lastIdx;
  logic             gateWr, gateRd;

  eppCtrl #(.BYTES(BYTES), .IDX_W(IDX_W), .ACK_TIMEOUT(ACK_TIMEOUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostSize(hostSize), .gateWr(gateWr), .gateRd(gateRd),
    .perAck(perAck), .perErr(perErr), .stb(stb), .byteIdx(byteIdx),
    .lastIdx(lastIdx), .perReq(perReq), .hostBusy(hostBusy)
  );

  eppDatapath #(.BYTES(BYTES), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hostWr(hostWr), .hostAddr(hostAddr),
    .hostSize(hostSize), .hostWdata(hostWdata), .byteIdx(byteIdx),
    .lastIdx(lastIdx), .perStatus(perStatus), .perRbyte(perRbyte),
    .hostRdata(hostRdata), .hostDone(hostDone), .portData(portData),
    .portDataLoad(portDataLoad), .portCtrl(portCtrl), .portCtrlLoad(portCtrlLoad),
    .perWbyte(perWbyte), .perWrite(perWrite), .perAddrCyc(perAddrCyc),
    .gateWr(gateWr), .gateRd(gateRd)
  );

endmodule

// File: rtl/eppCycleEngineChecker.sv
module eppCycleEngineChecker (
  input logic       clk,
  input logic       rstN,
  input logic       hostDone,
  input logic       hostBusy,
  input logic [7:0] portCtrl,
  input logic       portCtrlLoad,
  input logic       perReq,
  input logic       perAddrCyc,
  input logic       perWrite,
  input logic [7:0] perWbyte,
  input logic       perAck,
  input logic       perErr
);

  assert_wrGate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (perReq && perWrite) |-> ((portCtrl & 8'h2F) == 8'h04));

  assert_rdGate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (perReq && !perWrite) |-> ((portCtrl & 8'h2F) == 8'h24));

  assert_holdByte_R7: assert property (@(posedge clk) disable iff (!rstN)
    (perReq && !perAck && !perErr) |=>
      (!perReq || ($stable(perWbyte) && $stable(perAddrCyc) && $stable(perWrite))));

  assert_gapAfterAck_R7: assert property (@(posedge clk) disable iff (!rstN)
    (perReq && perAck && !perErr) |=> !perReq);

  assert_failEnds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (perReq && perErr) |=> (!hostBusy && hostDone));

  assert_busyCovers_R11: assert property (@(posedge clk) disable iff (!rstN)
    perReq |-> hostBusy);

  assert_ctrlLoad_R3: assert property (@(posedge clk) disable iff (!rstN)
    portCtrlLoad |-> (portCtrl != $past(portCtrl)));

  always @(posedge clk) begin
    if (rstN) begin
      assert_ctrlForced_R3: assert (portCtrl[7:6] == 2'b11);
    end
  end

endmodule

bind eppCycleEngine eppCycleEngineChecker u_chk (
  .clk(clk), .rstN(rstN), .hostDone(hostDone), .hostBusy(hostBusy),
  .portCtrl(portCtrl), .portCtrlLoad(portCtrlLoad), .perReq(perReq),
  .perAddrCyc(perAddrCyc), .perWrite(perWrite), .perWbyte(perWbyte),
  .perAck(perAck), .perErr(perErr)
);

// File: tb/test_eppCycleEngine.sv
`timescale 1ns/1ps
module test_eppCycleEngine;

  localparam int TO = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostReq = 1'b0, hostWr = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [1:0]  hostSize = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostDone, hostBusy;
  logic [7:0]  portData, portCtrl;
  logic        portDataLoad, portCtrlLoad;
  logic [7:1]  perStatus = 7'b1101101;
  logic        perReq, perAddrCyc, perWrite;
  logic [7:0]  perWbyte;
  logic [7:0]  perRbyte = 8'h00;
  logic        perAck = 1'b0, perErr = 1'b0;

  int tests = 0, fails = 0;

  // peripheral model state
  int lat = 1, cnt = 0, failAt = -1, byteSeen = 0, reqCycles = 0;
  int logN = 0, dLoads = 0, cLoads = 0;
  logic [7:0] rdNext = 8'hA0;
  logic [7:0] logB [64];
  logic       logA [64];

  always #5 clk = ~clk;

  eppCycleEngine #(.DATA_W(32), .ACK_TIMEOUT(TO)) i_eppCycleEngine (
    .clk(clk), .rstN(rstN), .hostReq(hostReq), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostDone(hostDone), .hostBusy(hostBusy),
    .portData(portData), .portDataLoad(portDataLoad), .portCtrl(portCtrl),
    .portCtrlLoad(portCtrlLoad), .perStatus(perStatus), .perReq(perReq),
    .perAddrCyc(perAddrCyc), .perWrite(perWrite), .perWbyte(perWbyte),
    .perRbyte(perRbyte), .perAck(perAck), .perErr(perErr)
  );

  always @(negedge clk) begin
    perAck = 1'b0;
    perErr = 1'b0;
    if (portDataLoad) dLoads++;
    if (portCtrlLoad) cLoads++;
    if (perReq) begin
      reqCycles++;
      if (cnt >= lat) begin
        if (byteSeen == failAt) perErr = 1'b1;
        else begin
          perAck = 1'b1;
          if (logN < 64) begin
            logB[logN] = perWrite ? perWbyte : rdNext;
            logA[logN] = perAddrCyc;
          end
          logN++;
          if (!perWrite) begin
            perRbyte = rdNext;
            rdNext   = rdNext + 8'd1;
          end
        end
        byteSeen++;
        cnt = 0;
      end else cnt++;
    end else cnt = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic doAccess(input logic wr, input logic [2:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd, output int busy);
    int n;
    @(negedge clk);
    hostReq = 1'b1; hostWr = wr; hostAddr = a; hostSize = sz; hostWdata = wd;
    byteSeen = 0;
    @(negedge clk);
    hostReq = 1'b0;
    busy = 0; n = 0;
    while (!hostDone && n < 5000) begin
      if (hostBusy) busy++;
      @(negedge clk);
      n++;
    end
    if (n >= 5000) chk("R11 done never seen", 32'h0, 32'h1);
    rd = hostRdata;
  endtask

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 3'd2, 2'd0, 32'h0,  32'h000000CC},  // R2 control reset
    '{1'b0, 3'd0, 2'd0, 32'h0,  32'h000000FF},  // R2 data-out reset
    '{1'b0, 3'd1, 2'd0, 32'h0,  32'h000000DA},  // R9 status, flag clear
    '{1'b0, 3'd4, 2'd2, 32'h0,  32'hFFFFFFFF},  // R5 gated read 32
    '{1'b0, 3'd3, 2'd2, 32'h0,  32'h000000FF},  // R5 gated addr read 8
    '{1'b0, 3'd4, 2'd1, 32'h0,  32'h0000FFFF},  // R5 gated read 16
    '{1'b1, 3'd2, 2'd0, 32'h04, 32'h0},         // write-mode control
    '{1'b0, 3'd2, 2'd0, 32'h0,  32'h000000C4},  // R3 bits 7:6 forced
    '{1'b1, 3'd0, 2'd0, 32'h5A, 32'h0},
    '{1'b0, 3'd0, 2'd0, 32'h0,  32'h0000005A},  // R1 data-out
    '{1'b0, 3'd4, 2'd0, 32'h0,  32'h000000FF},  // R5 read in write mode
    '{1'b0, 3'd6, 2'd0, 32'h0,  32'h000000FF}   // R1 unused offset
  };

  function automatic string tagFor(input int i);
    if (i < 2) return "R2";
    if (i == 2) return "R9";
    if (VEC[i].addr == 3'd3 || VEC[i].addr == 3'd4) return "R5";
    if (VEC[i].addr == 3'd2) return "R3";
    return "R1";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int busy, base, rq, dl, cl;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R2 reset state at the ports
    chk("R2 portCtrl", 32'(portCtrl), 32'hCC);
    chk("R2 portData", 32'(portData), 32'hFF);
    chk("R2 busy/req", {30'b0, hostBusy, perReq}, 32'h0);

    for (int i = 0; i < 12; i++) begin
      doAccess(VEC[i].wr, VEC[i].addr, VEC[i].size, VEC[i].wdata, rd, busy);
      if (!VEC[i].wr) chk(tagFor(i), rd, VEC[i].exp);
    end
    chk("R4 gated accesses issued no peripheral cycle", 32'(logN), 32'd0);

    // R3 equal-value writes produce no load pulse
    dl = dLoads; cl = cLoads;
    doAccess(1'b1, 3'd2, 2'd0, 32'h04, rd, busy);
    doAccess(1'b1, 3'd2, 2'd0, 32'hC4, rd, busy);
    doAccess(1'b1, 3'd0, 2'd0, 32'h5A, rd, busy);
    @(negedge clk);
    chk("R3 no ctrl load on equal value", 32'(cLoads - cl), 32'd0);
    chk("R3 no data load on equal value", 32'(dLoads - dl), 32'd0);
    doAccess(1'b1, 3'd0, 2'd0, 32'h5B, rd, busy);
    @(negedge clk);
    chk("R3 one data load pulse", 32'(dLoads - dl), 32'd1);
    chk("R3 portData updated", 32'(portData), 32'h5B);

    // R6 32-bit data write, LSB first; R11 busy
    base = logN;
    doAccess(1'b1, 3'd4, 2'd2, 32'h11223344, rd, busy);
    chk("R6 byte count", 32'(logN - base), 32'd4);
    chk("R6 order", {logB[base], logB[base+1], logB[base+2], logB[base+3]}, 32'h44332211);
    chk("R6 data cycle flag", {31'b0, logA[base] | logA[base+3]}, 32'h0);
    chk("R11 busy while transferring", 32'(busy > 4), 32'd1);
    @(negedge clk);
    chk("R11 busy low after done", {31'b0, hostBusy}, 32'h0);

    // R6 address window moves one byte regardless of size
    base = logN;
    doAccess(1'b1, 3'd3, 2'd2, 32'hCAFE00A7, rd, busy);
    chk("R6 addr byte count", 32'(logN - base), 32'd1);
    chk("R6 addr byte", {23'b0, logA[base], logB[base]}, 32'h1A7);

    // R6 16-bit write, R7 handshake exercised with latency 3
    lat = 3;
    base = logN;
    doAccess(1'b1, 3'd4, 2'd1, 32'h0000BEEF, rd, busy);
    chk("R7 bytes across slow acks", {16'b0, logB[base], logB[base+1]}, 32'hEFBE);
    lat = 1;

    // R4 control pattern wrong for writes (strobe bit set)
    doAccess(1'b1, 3'd2, 2'd0, 32'h05, rd, busy);
    base = logN; rq = reqCycles;
    doAccess(1'b1, 3'd4, 2'd2, 32'hDEADBEEF, rd, busy);
    chk("R4 write dropped", 32'(logN - base), 32'd0);
    chk("R4 no perReq", 32'(reqCycles - rq), 32'd0);

    // R5 read mode reads
    doAccess(1'b1, 3'd2, 2'd0, 32'h24, rd, busy);
    rdNext = 8'hA0;
    doAccess(1'b0, 3'd4, 2'd1, 32'h0, rd, busy);
    chk("R5 16-bit read assembled", rd, 32'h0000A1A0);
    doAccess(1'b0, 3'd3, 2'd2, 32'h0, rd, busy);
    chk("R6 addr read one byte", rd, 32'h000000A2);
    base = logN;
    doAccess(1'b1, 3'd4, 2'd0, 32'h77, rd, busy);
    chk("R4 write dropped in read mode", 32'(logN - base), 32'd0);

    // R8 silent peripheral: timeout after TO request cycles
    perStatus = 7'b0001001;
    lat = 100000; rq = reqCycles;
    doAccess(1'b0, 3'd4, 2'd0, 32'h0, rd, busy);
    lat = 1;
    chk("R8 request cycles before timeout", 32'(reqCycles - rq), 32'(TO));
    chk("R8 unreceived byte stays ones", rd, 32'h000000FF);
    doAccess(1'b0, 3'd1, 2'd0, 32'h0, rd, busy);
    chk("R9 status bit0 shows flag", rd, 32'h00000013);

    // R10 clear semantics
    doAccess(1'b1, 3'd1, 2'd0, 32'hFE, rd, busy);
    doAccess(1'b0, 3'd1, 2'd0, 32'h0, rd, busy);
    chk("R10 write 0 keeps flag", rd, 32'h00000013);
    doAccess(1'b1, 3'd1, 2'd0, 32'h01, rd, busy);
    doAccess(1'b0, 3'd1, 2'd0, 32'h0, rd, busy);
    chk("R10 write 1 clears flag", rd, 32'h00000012);

    // R8 error on second byte of a 32-bit read
    rdNext = 8'hB0; failAt = 1;
    doAccess(1'b0, 3'd4, 2'd2, 32'h0, rd, busy);
    failAt = -1;
    chk("R8 partial read keeps ones", rd, 32'hFFFFFFB0);

    // R8 error on third byte of a 32-bit write
    doAccess(1'b1, 3'd1, 2'd0, 32'h01, rd, busy);
    doAccess(1'b1, 3'd2, 2'd0, 32'h04, rd, busy);
    base = logN; failAt = 2;
    doAccess(1'b1, 3'd4, 2'd2, 32'h55667788, rd, busy);
    failAt = -1;
    chk("R8 write stopped after failure", 32'(logN - base), 32'd2);
    doAccess(1'b0, 3'd1, 2'd0, 32'h0, rd, busy);
    chk("R8 flag set by error", rd, 32'h00000013);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule